// File: doc/BRIEF.md
# A/D Scan Sequencer with Sample FIFO

This block drives an analog-to-digital converter through a simple start/done handshake and steps it over a window of input channels. A trigger launches either one conversion on the current channel or a full pass over every channel from the low bound up to the high bound. Each result is a 16-bit two's-complement word. Results are queued in a 128-entry sample FIFO. A host reads them through a byte-wide register port, low byte first and then high byte.

The converter's results form a valid-only stream. `conv_done` marks a valid word on `conv_data`, and the block never stalls the converter: there is no ready signal. When the FIFO is full, an arriving sample is dropped and a sticky overflow flag records the loss. Triggers come from one of two places, selected by a gate bit. With the gate clear, a host write to the command register starts a conversion. With the gate set, only the external or timer trigger pins can start one. A trigger that arrives while a conversion or scan is in progress is ignored.

Top module: `adc_scan_ctl`

Register map (3-bit address, 8-bit data, reads combinational):

| Addr | Write | Read |
|------|-------|------|
| 0 | command: bit0 go, bit1 FIFO clear | sample low byte (no pop) |
| 1 | no effect | sample high byte (pops) |
| 2 | channel window | channel window |
| 3 | mode: bit0 scan, bit1 gate, bit2 diff | status |
| 4 | threshold bits 5:0 | threshold |
| 5 | no effect | FIFO fill count |
| 6 | no effect | current channel |

## Requirements
- R1: After reset, status (addr 3) reads 0x04 (only the empty bit set), the fill count reads 0, the threshold reads 1 and `conv_start` is low.
- R2: Register 2 holds the high channel in bits 7:4 and the low channel in bits 3:0; it reads back as written, and a write while idle sets the current channel (addr 6) to the low channel.
- R3: With the diff bit (mode bit2) set, the low bound, the high bound and the current channel are taken modulo 8, so channels stay within 0 to 7.
- R4: With the scan bit (mode bit0) clear, each trigger converts the current channel once; afterwards the current channel becomes channel+1, or the low channel if the converted channel was the high channel.
- R5: With the scan bit set, each trigger converts every channel from the low channel up to the high channel in ascending order, and the current channel then returns to the low channel.
- R6: Status bit0 (busy) is high from the edge that accepts a trigger until the edge that takes the last result of that conversion or scan; triggers that arrive while busy are ignored.
- R7: With the gate bit (mode bit1) clear, a write of command bit0 starts a conversion and the `ext_trig`/`tmr_trig` pins are ignored; with it set, the command write is ignored and a high level on `ext_trig` or `tmr_trig` starts one.
- R8: `conv_start` is a one-cycle pulse with the channel on `conv_chan`; a `conv_done` while a conversion is outstanding stores `conv_data`, and the next scan channel is launched on the same edge.
- R9: Samples leave the FIFO in arrival order; reading addr 0 returns bits 7:0 of the oldest sample without popping, reading addr 1 returns bits 15:8 and pops it, and addr 5 returns the number of stored samples (at most 128).
- R10: Status bit3 is high exactly when the fill count is at least the 6-bit threshold in register 4.
- R11: A sample arriving while the FIFO holds 128 entries is dropped and sets status bit1 (overflow); the flag clears on the next high-byte read that pops a sample.
- R12: Writing command bit1 empties the FIFO and clears the overflow flag; status bit2 reports an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on addr 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ext_trig | input | 1 | External trigger, active high, used when gated |
| tmr_trig | input | 1 | Timer trigger, active high, used when gated |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | 4 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 16 | Converter result, two's complement |

## Verification
`conv_start` rises on the first edge after an accepted trigger. A result enters the FIFO on the edge that samples `conv_done`. The next scan channel's start appears on that same edge. Register reads are combinational, so a value can be sampled in the same cycle as its strobe, and a high-byte pop takes effect at the following edge. The bench drives at the falling edge and samples 1 ns later. It polls the busy bit through the status register instead of assuming a fixed latency. A monitor checks each start pulse at the first falling edge after it appears, against the channel order predicted in the scoreboard.

// File: rtl/adcs_pkg.sv
`timescale 1ns/1ps
package adcs_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_WAIT = 1'b1} sq_state_t;

  localparam logic [2:0] A_DLO  = 3'd0;
  localparam logic [2:0] A_DHI  = 3'd1;
  localparam logic [2:0] A_CHAN = 3'd2;
  localparam logic [2:0] A_MODE = 3'd3;
  localparam logic [2:0] A_THR  = 3'd4;
  localparam logic [2:0] A_FILL = 3'd5;
  localparam logic [2:0] A_CUR  = 3'd6;

  localparam int CMD_GO   = 0;
  localparam int CMD_FCLR = 1;
  localparam int MD_SCAN  = 0;
  localparam int MD_GATE  = 1;
  localparam int MD_DIFF  = 2;
endpackage

// File: rtl/adcs_fifo.sv
`timescale 1ns/1ps
module adcs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, pop_ok, push_ok;

  assign empty   = (count == '0);
  assign full    = (count == FULLC);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      if (push_ok && !pop_ok)      count <= count + {{(CW-1){1'b0}}, 1'b1};
      else if (pop_ok && !push_ok) count <= count - {{(CW-1){1'b0}}, 1'b1};
      if (push && !push_ok) ovf <= 1'b1;
      else if (pop_ok)      ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/adcs_seq.sv
`timescale 1ns/1ps
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            scan_en,
  input  logic            diff_mode,
  input  logic [CH_W-1:0] lo,
  input  logic [CH_W-1:0] hi,
  input  logic            chan_load,
  input  logic [CH_W-1:0] load_lo,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic [CH_W-1:0] cur_ch,
  output logic            busy,
  output logic            smp_valid
);
  localparam logic [CH_W-1:0] DMASK = {1'b0, {(CH_W-1){1'b1}}};
  localparam logic [CH_W-1:0] ONE   = {{(CH_W-1){1'b0}}, 1'b1};

  sq_state_t state;
  logic [CH_W-1:0] lo_m, hi_m, step, first;
  logic at_hi, more;

  function automatic logic [CH_W-1:0] fold(input logic [CH_W-1:0] c, input logic d);
    return d ? (c & DMASK) : c;
  endfunction

  assign lo_m  = fold(lo, diff_mode);
  assign hi_m  = fold(hi, diff_mode);
  assign step  = fold(cur_ch + ONE, diff_mode);
  assign first = scan_en ? lo_m : fold(cur_ch, diff_mode);
  assign at_hi = (cur_ch == hi_m);
  assign more  = scan_en && !at_hi;

  assign busy      = (state == SQ_WAIT);
  assign smp_valid = busy && conv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      cur_ch     <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (trig) begin
            conv_chan  <= first;
            cur_ch     <= first;
            conv_start <= 1'b1;
            state      <= SQ_WAIT;
          end else if (chan_load) begin
            cur_ch <= fold(load_lo, diff_mode);
          end
        end
        SQ_WAIT: begin
          if (conv_done) begin
            if (more) begin
              cur_ch     <= step;
              conv_chan  <= step;
              conv_start <= 1'b1;
            end else begin
              state  <= SQ_IDLE;
              cur_ch <= (scan_en || at_hi) ? lo_m : step;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctl.sv
`timescale 1ns/1ps
module adc_scan_ctl
  import adcs_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CH_W  = 4,
  parameter int DEPTH = 128,
  parameter int THR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               ext_trig,
  input  logic               tmr_trig,
  output logic               conv_start,
  output logic [CH_W-1:0]    conv_chan,
  input  logic               conv_done,
  input  logic [2*BUS_W-1:0] conv_data
);
  localparam int DW    = 2 * BUS_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [2*CH_W-1:0] chan_reg;
  logic [THR_W-1:0]  thr_reg;
  logic              scan_en, irq_gate, diff_mode;
  logic              wr_cmd, rd_pop, trig, sw_go, hw_go, fclr;
  logic              seq_busy, smp_valid;
  logic [CH_W-1:0]   cur_ch;
  logic [DW-1:0]     head;
  logic [CNT_W-1:0]  fcount;
  logic              fempty, fovf, thr_hit;
  logic [BUS_W-1:0]  status;

  assign wr_cmd = bus_wr && (bus_addr == A_DLO);
  assign rd_pop = bus_rd && (bus_addr == A_DHI);
  assign sw_go  = wr_cmd && bus_wdata[CMD_GO] && !irq_gate;
  assign hw_go  = irq_gate && (ext_trig || tmr_trig);
  assign trig   = (sw_go || hw_go) && !seq_busy;
  assign fclr   = wr_cmd && bus_wdata[CMD_FCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_reg  <= '0;
      thr_reg   <= {{(THR_W-1){1'b0}}, 1'b1};
      scan_en   <= 1'b0;
      irq_gate  <= 1'b0;
      diff_mode <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CHAN: chan_reg <= bus_wdata[2*CH_W-1:0];
        A_MODE: begin
          scan_en   <= bus_wdata[MD_SCAN];
          irq_gate  <= bus_wdata[MD_GATE];
          diff_mode <= bus_wdata[MD_DIFF];
        end
        A_THR:   thr_reg <= bus_wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  adcs_seq #(.CH_W(CH_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .scan_en   (scan_en),
    .diff_mode (diff_mode),
    .lo        (chan_reg[CH_W-1:0]),
    .hi        (chan_reg[2*CH_W-1:CH_W]),
    .chan_load (bus_wr && (bus_addr == A_CHAN)),
    .load_lo   (bus_wdata[CH_W-1:0]),
    .conv_done (conv_done),
    .conv_start(conv_start),
    .conv_chan (conv_chan),
    .cur_ch    (cur_ch),
    .busy      (seq_busy),
    .smp_valid (smp_valid)
  );

  adcs_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (fclr),
    .push (smp_valid),
    .wdata(conv_data),
    .pop  (rd_pop),
    .head (head),
    .count(fcount),
    .empty(fempty),
    .ovf  (fovf)
  );

  assign thr_hit = (fcount >= CNT_W'(thr_reg));
  assign status  = BUS_W'({diff_mode, irq_gate, scan_en, thr_hit, fempty, fovf, seq_busy});

  always_comb begin
    case (bus_addr)
      A_DLO:   bus_rdata = head[BUS_W-1:0];
      A_DHI:   bus_rdata = head[DW-1:BUS_W];
      A_CHAN:  bus_rdata = BUS_W'(chan_reg);
      A_MODE:  bus_rdata = status;
      A_THR:   bus_rdata = BUS_W'(thr_reg);
      A_FILL:  bus_rdata = BUS_W'(fcount);
      A_CUR:   bus_rdata = BUS_W'(cur_ch);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_scan_ctl_chk.sv
`timescale 1ns/1ps
module adc_scan_ctl_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             conv_done,
  input logic             busy,
  input logic             wr_cmd,
  input logic             go_bit,
  input logic             clr_bit,
  input logic             pop_req,
  input logic             irq_gate,
  input logic             ext_trig,
  input logic             tmr_trig,
  input logic [CNT_W-1:0] fcount,
  input logic             fempty,
  input logic             fovf
);
  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R7
  sw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_cmd && go_bit && irq_gate && !ext_trig && !tmr_trig) |=> !busy);

  // R12
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && clr_bit) |=> (fcount == '0 && !fovf && fempty));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcount <= CNT_W'(DEPTH));

  // R11
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !fempty && !conv_done) |=> !fovf);

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && fcount == CNT_W'(DEPTH) && !pop_req && !(wr_cmd && clr_bit)) |=> fovf);
endmodule

bind adc_scan_ctl adc_scan_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_start(conv_start),
  .conv_done (conv_done),
  .busy      (seq_busy),
  .wr_cmd    (wr_cmd),
  .go_bit    (bus_wdata[0]),
  .clr_bit   (bus_wdata[1]),
  .pop_req   (rd_pop),
  .irq_gate  (irq_gate),
  .ext_trig  (ext_trig),
  .tmr_trig  (tmr_trig),
  .fcount    (fcount),
  .fempty    (fempty),
  .fovf      (fovf)
);

// File: tb/adc_scan_ctl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ext_trig = 1'b0, tmr_trig = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [15:0] conv_data = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0]  qc[$];
  logic [15:0] qd[$];

  always #2.5 clk = ~clk;

  adc_scan_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .tmr_trig(tmr_trig),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data)
  );

  function automatic logic [15:0] smp(input logic [3:0] ch);
    return {~ch, ch, ch ^ 4'h5, 4'h9};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ch(input logic [3:0] ch, input bit store);
    qc.push_back(ch);
    if (store) qd.push_back(smp(ch));
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_read(3'd3, s);
      if (!s[0]) break;
    end
  endtask

  task automatic read_sample(input logic [15:0] exp, input string tag);
    logic [7:0] lo, hi;
    bus_read(3'd0, lo);
    bus_read(3'd1, hi);
    chk({hi, lo} == exp, tag, {hi, lo}, exp);
  endtask

  task automatic read_next(input string tag);
    logic [15:0] e;
    e = (qd.size() > 0) ? qd.pop_front() : 16'hxxxx;
    read_sample(e, tag);
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) ext_trig = 1'b1; else tmr_trig = 1'b1;
    @(posedge clk); #1;
    ext_trig = 1'b0; tmr_trig = 1'b0;
  endtask

  // converter model and start-order monitor
  initial begin
    forever begin
      logic [3:0] ch;
      logic [3:0] e;
      @(negedge clk);
      conv_done = 1'b0;
      if (rst_n && conv_start) begin
        ch = conv_chan;
        e = (qc.size() > 0) ? qc.pop_front() : 4'hx;
        chk(ch === e, "R5 start channel order", ch, e);
        @(negedge clk);
        chk(!conv_start, "R8 start pulse width", conv_start, 0);
        repeat (2) @(negedge clk);
        conv_done = 1'b1;
        conv_data = smp(ch);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    bus_read(3'd3, r); chk(r == 8'h04, "R1 status", r, 8'h04);
    bus_read(3'd5, r); chk(r == 8'h00, "R1 fill", r, 0);
    bus_read(3'd4, r); chk(r == 8'h01, "R1 threshold", r, 1);
    chk(!conv_start, "R1 conv_start", conv_start, 0);

    // R2 channel window
    bus_write(3'd2, 8'h53);
    bus_read(3'd2, r); chk(r == 8'h53, "R2 readback", r, 8'h53);
    bus_read(3'd6, r); chk(r == 8'h03, "R2 current=low", r, 3);

    // R4 single conversions 3,4,5,3
    bus_write(3'd3, 8'h00);
    expect_ch(4'd3, 1); expect_ch(4'd4, 1); expect_ch(4'd5, 1); expect_ch(4'd3, 1);
    for (int i = 0; i < 4; i++) begin
      bus_write(3'd0, 8'h01);
      wait_idle();
    end
    bus_read(3'd6, r); chk(r == 8'h04, "R4 current after wrap", r, 4);
    bus_read(3'd5, r); chk(r == 8'h04, "R9 fill count", r, 4);
    for (int i = 0; i < 4; i++) read_next("R9 fifo order");
    bus_read(3'd3, r); chk(r[2] == 1'b1, "R12 empty bit", r, 8'h04);

    // R5 scan 0..3, second trigger while busy ignored (R6)
    bus_write(3'd3, 8'h01);
    bus_write(3'd2, 8'h30);
    for (int c = 0; c < 4; c++) expect_ch(4'(c), 1);
    bus_write(3'd0, 8'h01);
    bus_read(3'd3, r); chk(r[0] == 1'b1, "R6 busy during scan", r[0], 1);
    bus_write(3'd0, 8'h01);
    wait_idle();
    bus_read(3'd5, r); chk(r == 8'h04, "R6 busy trigger ignored", r, 4);
    bus_read(3'd6, r); chk(r == 8'h00, "R5 current back to low", r, 0);
    for (int i = 0; i < 4; i++) read_next("R5 scan data");

    // R3 differential: window 0xA9 -> 1..2
    bus_write(3'd3, 8'h05);
    bus_write(3'd2, 8'hA9);
    expect_ch(4'd1, 1); expect_ch(4'd2, 1);
    bus_write(3'd0, 8'h01);
    wait_idle();
    bus_read(3'd5, r); chk(r == 8'h02, "R3 diff count", r, 2);
    bus_read(3'd6, r); chk(r == 8'h01, "R3 diff current", r, 1);
    read_next("R3 diff data"); read_next("R3 diff data");

    // R7 gating
    bus_write(3'd3, 8'h02);
    bus_write(3'd2, 8'h77);
    bus_write(3'd0, 8'h01);
    repeat (10) @(posedge clk);
    bus_read(3'd5, r); chk(r == 8'h00, "R7 gated command ignored", r, 0);
    expect_ch(4'd7, 1);
    pulse(1'b1); wait_idle();
    expect_ch(4'd7, 1);
    pulse(1'b0); wait_idle();
    bus_read(3'd5, r); chk(r == 8'h02, "R7 pin triggers", r, 2);
    read_next("R7 data"); read_next("R7 data");
    bus_write(3'd3, 8'h00);
    pulse(1'b1); pulse(1'b0);
    repeat (10) @(posedge clk);
    bus_read(3'd5, r); chk(r == 8'h00, "R7 pins ignored ungated", r, 0);

    // R10 threshold
    bus_write(3'd4, 8'h03);
    bus_read(3'd4, r); chk(r == 8'h03, "R10 threshold readback", r, 3);
    bus_write(3'd2, 8'h22);
    for (int i = 0; i < 3; i++) begin
      expect_ch(4'd2, 1);
      bus_write(3'd0, 8'h01);
      wait_idle();
      bus_read(3'd3, r);
      chk(r[3] == (i == 2), "R10 threshold flag", r[3], (i == 2));
    end
    for (int i = 0; i < 3; i++) read_next("R10 data");

    // R11 overflow
    bus_write(3'd3, 8'h01);
    bus_write(3'd2, 8'hF0);
    for (int t = 0; t < 9; t++) begin
      for (int c = 0; c < 16; c++) expect_ch(4'(c), 0);
      bus_write(3'd0, 8'h01);
      wait_idle();
    end
    bus_read(3'd5, r); chk(r == 8'h80, "R11 fill at depth", r, 8'h80);
    bus_read(3'd3, r); chk(r[1] == 1'b1, "R11 overflow set", r[1], 1);
    read_sample(smp(4'd0), "R11 oldest kept");
    bus_read(3'd3, r); chk(r[1] == 1'b0, "R11 overflow cleared by read", r[1], 0);
    bus_read(3'd5, r); chk(r == 8'h7F, "R11 fill after read", r, 8'h7F);
    for (int c = 0; c < 16; c++) expect_ch(4'(c), 0);
    bus_write(3'd0, 8'h01);
    wait_idle();
    bus_read(3'd3, r); chk(r[1] == 1'b1, "R11 overflow again", r[1], 1);

    // R12 FIFO clear
    bus_write(3'd0, 8'h02);
    bus_read(3'd5, r); chk(r == 8'h00, "R12 fill cleared", r, 0);
    bus_read(3'd3, r); chk(r[2:1] == 2'b10, "R12 empty and no overflow", r[2:1], 2'b10);

    repeat (10) @(posedge clk);
    chk(qc.size() == 0, "R5 all starts seen", qc.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule